// File: doc/BRIEF.md
# Word-Multiplexed Logical Channel Link

This block holds both ends of one point-to-point physical link between two processing cells. Several logical channels travel in the same direction over that link. Their traffic is interleaved one 32-bit word at a time, and the link accepts at most one word every second clock cycle. On the sending side each local channel offers a valid/ready word stream. A round-robin arbiter hands the next free link slot to one channel that has a word waiting and credit left. That word goes out on the link tagged with a 3-bit link channel ID.

On the receiving side the ID is matched against a static map, which steers the word into the small FIFO of the matching local channel. That FIFO then presents it as a valid/ready stream. Flow control works per channel through credits. Each sender-side counter starts at the receive FIFO depth, goes down by one for each word sent, and goes up by one for each word popped at the receiver. A stalled consumer on one channel therefore stops only its own channel. Channels with nothing to send take no link slots.

The map is a static configuration input that software sets before traffic starts. Entry i, held in bits [3i+2:3i], gives the link ID of local channel i. The entries must be distinct. The link wires are also brought out so that the tagged words can be observed.

Top module: `wordmux_link`

## Requirements
- R1: The link carries at most one word every two cycles: `link_vld` is never high in two consecutive cycles. While any channel has a word and credit, a word is sent every second cycle.
- R2: A word accepted (`tx_valid[i]` and `tx_ready[i]` high at a clock edge) appears on the link in the following cycle. `link_id` then equals map entry i (bits [3i+2:3i] of `chan_map`) and `link_data` equals the accepted word. `rx_valid` of the receiving channel goes high one cycle after that.
- R3: A link word is delivered on the local receive channel i whose map entry equals `link_id`, and on no other channel. Words of a channel arrive in the order they were accepted and are unchanged.
- R4: A channel with `tx_valid` low takes no link slots. All slots go to the channels that have words.
- R5: Round-robin arbitration: when several channels request without a break, their counts of accepted words over any window differ by at most one.
- R6: Per channel, at most DEPTH words are outstanding, meaning accepted but not yet popped at the receiver. Once that limit is reached, `tx_ready` of the channel stays low until a pop returns a credit.
- R7: A channel that is out of credit does not slow the others. The remaining requesting channels share all link slots.
- R8: Reset empties every receive FIFO, sets every credit counter to DEPTH and leaves the link idle.
- R9: While `rx_valid[i]` is high and `rx_ready[i]` is low, `rx_valid[i]` stays high and the word on `rx_data` for channel i does not change.
- R10: At most one bit of `tx_ready` is high in any cycle, and only for a channel whose `tx_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_map | input | NCH*3 | Static map, entry i in bits [3i+2:3i] is the link ID of local channel i |
| tx_valid | input | NCH | Sender-side word offered, one bit per channel |
| tx_data | input | NCH*32 | Sender-side words, channel i in bits [32i+31:32i] |
| tx_ready | output | NCH | Sender-side word taken this cycle |
| rx_valid | output | NCH | Receiver-side word available, one bit per channel |
| rx_ready | input | NCH | Receiver-side consumer accepts the word |
| rx_data | output | NCH*32 | Receiver-side words, channel i in bits [32i+31:32i] |
| link_vld | output | 1 | A word is on the physical link this cycle |
| link_id | output | 3 | Link channel ID of the word on the link |
| link_data | output | 32 | Data word on the link |

## Verification
The bench stalls one receive channel while a second channel keeps sending. A design whose credit does not stop at the FIFO depth would overrun that FIFO and lose words. A design that blocks the link on the stalled channel would starve the other channel of slots. A run with all channels busy checks both the two-cycle link spacing and the round-robin balance; a sender that ignores the spacing, or an arbiter with fixed priority, shows up as a wrong count. A single word sent to a consumer that is not ready checks the link ID, the one-cycle latency at each stage and that the word is held. A reset issued while a FIFO is full must bring back the full credit, or the next burst stops short.

// File: rtl/wordmux_pkg.sv
package wordmux_pkg;
  localparam int WORD_W = 32;
  localparam int ID_W   = 3;
  localparam int MAX_CH = 1 << ID_W;

  typedef struct packed {
    logic              vld;
    logic [ID_W-1:0]   id;
    logic [WORD_W-1:0] data;
  } link_word_t;

  // Round-robin pick: the first requester after 'last', wrapping; MSB = found.
  function automatic logic [ID_W:0] rr_pick(input logic [MAX_CH-1:0] req,
                                            input logic [ID_W-1:0]   last);
    logic [ID_W:0]   res;
    logic [ID_W-1:0] cand;
    res = '0;
    for (int k = MAX_CH; k >= 1; k--) begin
      cand = last + ID_W'(k);
      if (req[cand]) res = {1'b1, cand};
    end
    return res;
  endfunction

  // Credit update: one spent per word sent, one returned per receiver pop.
  function automatic logic [7:0] credit_step(input logic [7:0] cnt,
                                             input logic take,
                                             input logic give);
    return cnt - {7'd0, take} + {7'd0, give};
  endfunction
endpackage

// File: rtl/wordmux_arb.sv
module wordmux_arb
  import wordmux_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  req,
  input  logic            en,
  output logic [NCH-1:0]  gnt,
  output logic            gnt_any
);
  logic [ID_W-1:0]   last_q;
  logic [MAX_CH-1:0] req_w;
  logic [ID_W:0]     pick;
  logic [ID_W-1:0]   gnt_idx;

  always_comb begin
    req_w          = '0;
    req_w[NCH-1:0] = req;
    pick           = rr_pick(req_w, last_q);
    gnt_any        = en & pick[ID_W];
    gnt_idx        = pick[ID_W-1:0];
    for (int i = 0; i < NCH; i++) gnt[i] = gnt_any && (gnt_idx == ID_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= ID_W'(NCH - 1);
    else if (gnt_any) last_q <= gnt_idx;
  end
endmodule

// File: rtl/wordmux_fifo.sv
module wordmux_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         avail,
  output logic [W-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          full, do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign avail   = (cnt_q != '0);
  assign do_push = push && !full;
  assign do_pop  = pop && avail;
  assign dout    = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/wordmux_tx.sv
module wordmux_tx
  import wordmux_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        tx_valid,
  input  logic [NCH*WORD_W-1:0] tx_data,
  input  logic [NCH*ID_W-1:0]   chan_map,
  input  logic [NCH-1:0]        credit_ret,
  output logic [NCH-1:0]        tx_ready,
  output link_word_t            link_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]     cred_q [NCH];
  logic [NCH-1:0]    has_cred, req, gnt;
  logic              gnt_any, slot_free;
  logic [ID_W-1:0]   sel_id;
  logic [WORD_W-1:0] sel_data;
  link_word_t        link_q;

  for (genvar i = 0; i < NCH; i++) begin : g_cred
    assign has_cred[i] = (cred_q[i] != '0);
    always_ff @(posedge clk) begin
      if (!rst_n) cred_q[i] <= CW'(DEPTH);
      else        cred_q[i] <= CW'(credit_step(8'(cred_q[i]), gnt[i], credit_ret[i]));
    end
  end

  assign req       = tx_valid & has_cred;
  assign slot_free = !link_q.vld;

  wordmux_arb #(.NCH(NCH)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .en      (slot_free),
    .gnt     (gnt),
    .gnt_any (gnt_any)
  );

  always_comb begin
    sel_id   = '0;
    sel_data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (gnt[i]) begin
        sel_id   = sel_id   | chan_map[i*ID_W +: ID_W];
        sel_data = sel_data | tx_data[i*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q <= '0;
    end else begin
      link_q.vld <= gnt_any;
      if (gnt_any) begin
        link_q.id   <= sel_id;
        link_q.data <= sel_data;
      end
    end
  end

  assign tx_ready = gnt;
  assign link_o   = link_q;
endmodule

// File: rtl/wordmux_rx.sv
module wordmux_rx
  import wordmux_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  link_word_t            link_i,
  input  logic [NCH*ID_W-1:0]   chan_map,
  input  logic [NCH-1:0]        rx_ready,
  output logic [NCH-1:0]        rx_valid,
  output logic [NCH*WORD_W-1:0] rx_data,
  output logic [NCH-1:0]        pop
);
  logic [NCH-1:0] hit;

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    assign hit[i] = link_i.vld && (link_i.id == chan_map[i*ID_W +: ID_W]);
    assign pop[i] = rx_valid[i] && rx_ready[i];

    wordmux_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (hit[i]),
      .din   (link_i.data),
      .pop   (pop[i]),
      .avail (rx_valid[i]),
      .dout  (rx_data[i*WORD_W +: WORD_W])
    );
  end
endmodule

// File: rtl/wordmux_link.sv
module wordmux_link
  import wordmux_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH*ID_W-1:0]   chan_map,
  input  logic [NCH-1:0]        tx_valid,
  input  logic [NCH*WORD_W-1:0] tx_data,
  output logic [NCH-1:0]        tx_ready,
  output logic [NCH-1:0]        rx_valid,
  input  logic [NCH-1:0]        rx_ready,
  output logic [NCH*WORD_W-1:0] rx_data,
  output logic                  link_vld,
  output logic [ID_W-1:0]       link_id,
  output logic [WORD_W-1:0]     link_data
);
  link_word_t     link_w;
  logic [NCH-1:0] credit_ret;

  wordmux_tx #(.NCH(NCH), .DEPTH(DEPTH)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .chan_map   (chan_map),
    .credit_ret (credit_ret),
    .tx_ready   (tx_ready),
    .link_o     (link_w)
  );

  wordmux_rx #(.NCH(NCH), .DEPTH(DEPTH)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_i   (link_w),
    .chan_map (chan_map),
    .rx_ready (rx_ready),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .pop      (credit_ret)
  );

  assign link_vld  = link_w.vld;
  assign link_id   = link_w.id;
  assign link_data = link_w.data;
endmodule

// File: rtl/wordmux_link_chk.sv
module wordmux_link_chk #(
  parameter int NCH   = 4,
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   tx_valid,
  input logic [NCH-1:0]   tx_ready,
  input logic [NCH-1:0]   rx_valid,
  input logic [NCH-1:0]   rx_ready,
  input logic [NCH*W-1:0] rx_data,
  input logic             link_vld
);
  logic tx_take;
  assign tx_take = |(tx_valid & tx_ready);

  AST_LINK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    link_vld |=> !link_vld); // R1
  AST_LINK_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> link_vld); // R2
  AST_LINK_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    link_vld |-> $past(tx_take)); // R2
  AST_SINGLE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_ready)); // R10
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready & ~tx_valid) == '0); // R10

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    int outstanding;
    always_ff @(posedge clk) begin
      if (!rst_n) outstanding <= 0;
      else outstanding <= outstanding + int'(tx_valid[i] && tx_ready[i])
                                      - int'(rx_valid[i] && rx_ready[i]);
    end
    AST_CREDIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      outstanding <= DEPTH); // R6
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid[i] && !rx_ready[i]) |=> (rx_valid[i] && $stable(rx_data[i*W +: W]))); // R9
  end
endmodule

bind wordmux_link wordmux_link_chk #(.NCH(NCH), .DEPTH(DEPTH), .W(wordmux_pkg::WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .rx_data  (rx_data),
  .link_vld (link_vld)
);

// File: tb/wordmux_link_test.sv
module wordmux_link_test;
  import wordmux_pkg::*;
  localparam int NCH   = 4;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  // local 0->5, 1->2, 2->7, 3->0
  logic [NCH*ID_W-1:0]   chan_map = {3'd0, 3'd7, 3'd2, 3'd5};
  logic [NCH-1:0]        tx_valid = '0;
  logic [NCH-1:0]        rx_ready = '0;
  logic [NCH*WORD_W-1:0] tx_data;
  logic [NCH-1:0]        tx_ready, rx_valid;
  logic [NCH*WORD_W-1:0] rx_data;
  logic                  link_vld;
  logic [ID_W-1:0]       link_id;
  logic [WORD_W-1:0]     link_data;

  wordmux_link #(.NCH(NCH), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .chan_map(chan_map),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .link_vld(link_vld), .link_id(link_id), .link_data(link_data)
  );

  int checks = 0;
  int fails  = 0;
  int hs_tx [NCH];
  int hs_rx [NCH];
  int link_cnt = 0;
  logic prev_link = 1'b0;

  function automatic logic [31:0] word_of(int ch, int k);
    return {4'hC, 4'(ch), 24'(k)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: sample at the falling edge, the values the next rising edge commits.
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin hs_tx[c] = 0; hs_rx[c] = 0; end
      link_cnt  = 0;
      prev_link = 1'b0;
    end else begin
      check($onehot0(tx_ready) && ((tx_ready & ~tx_valid) == '0), "R10",
            "tx_ready pattern", 32'(tx_ready), 32'(tx_valid));
      for (int c = 0; c < NCH; c++) begin
        if (tx_valid[c] && tx_ready[c]) hs_tx[c]++;
        if (rx_valid[c] && rx_ready[c]) begin
          check(rx_data[c*WORD_W +: WORD_W] == word_of(c, hs_rx[c]), "R3",
                "received word", rx_data[c*WORD_W +: WORD_W], word_of(c, hs_rx[c]));
          hs_rx[c]++;
        end
      end
      if (link_vld) begin
        check(!prev_link, "R1", "back-to-back link word", 32'(prev_link), 32'd0);
        link_cnt++;
      end
      prev_link = link_vld;
    end
  end

  // Each channel offers the word numbered by its count of accepted words.
  always @(posedge clk) begin
    #1;
    for (int c = 0; c < NCH; c++) tx_data[c*WORD_W +: WORD_W] = word_of(c, hs_tx[c]);
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tx_valid = '0; rx_ready = '0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic drain();
    tx_valid = '0; rx_ready = '1;
    cyc(12);
  endtask

  task automatic run_window(input logic [NCH-1:0] v, input logic [NCH-1:0] r,
                            input int n, output int d [NCH], output int dl);
    int base [NCH];
    int lbase;
    for (int c = 0; c < NCH; c++) base[c] = hs_tx[c];
    lbase = link_cnt;
    tx_valid = v; rx_ready = r;
    cyc(n);
    tx_valid = '0;
    for (int c = 0; c < NCH; c++) d[c] = hs_tx[c] - base[c];
    dl = link_cnt - lbase;
  endtask

  task automatic t_reset();
    do_reset();
    cyc(1);
    check(rx_valid == '0, "R8", "rx_valid after reset", 32'(rx_valid), 32'd0);
    check(!link_vld, "R8", "link idle after reset", 32'(link_vld), 32'd0);
    check(tx_ready == '0, "R8", "tx_ready after reset", 32'(tx_ready), 32'd0);
  endtask

  task automatic t_single();
    logic [31:0] w;
    bit got;
    got = 0; w = '0;
    rx_ready = '0; tx_valid = 4'b0100;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (tx_ready[2]) begin w = tx_data[2*WORD_W +: WORD_W]; got = 1; break; end
    end
    check(got, "R2", "channel 2 accepted", 32'(got), 32'd1);
    @(posedge clk); #1; tx_valid = '0;
    @(negedge clk);
    check(link_vld, "R2", "link word one cycle after accept", 32'(link_vld), 32'd1);
    check(link_id == chan_map[2*ID_W +: ID_W], "R2", "link id", 32'(link_id), 32'(chan_map[2*ID_W +: ID_W]));
    check(link_data == w, "R2", "link data", link_data, w);
    check(rx_valid == '0, "R2", "rx not yet valid", 32'(rx_valid), 32'd0);
    @(negedge clk);
    check(rx_valid == 4'b0100, "R3", "only local channel 2 valid", 32'(rx_valid), 32'h4);
    check(rx_data[2*WORD_W +: WORD_W] == w, "R3", "rx word", rx_data[2*WORD_W +: WORD_W], w);
    repeat (3) begin
      @(negedge clk);
      check(rx_valid[2] && rx_data[2*WORD_W +: WORD_W] == w, "R9", "held word",
            rx_data[2*WORD_W +: WORD_W], w);
    end
    @(posedge clk); #1;
    drain();
  endtask

  task automatic t_full();
    int d [NCH];
    int dl, mx, mn;
    run_window(4'hF, 4'hF, 40, d, dl);
    check(d[0] + d[1] + d[2] + d[3] == 20, "R1", "words in 40 cycles",
          32'(d[0] + d[1] + d[2] + d[3]), 32'd20);
    check(dl >= 19 && dl <= 20, "R1", "link words in 40 cycles", 32'(dl), 32'd20);
    mx = d[0]; mn = d[0];
    for (int c = 1; c < NCH; c++) begin
      if (d[c] > mx) mx = d[c];
      if (d[c] < mn) mn = d[c];
    end
    check(mx - mn <= 1, "R5", "round-robin spread", 32'(mx - mn), 32'd1);
    drain();
  endtask

  task automatic t_idle();
    int d [NCH];
    int dl;
    run_window(4'b1010, 4'hF, 40, d, dl);
    check(d[0] == 0 && d[2] == 0, "R4", "idle channels took slots", 32'(d[0] + d[2]), 32'd0);
    check(d[1] + d[3] == 20, "R4", "active channels got all slots", 32'(d[1] + d[3]), 32'd20);
    check(d[1] - d[3] <= 1 && d[3] - d[1] <= 1, "R5", "two-channel spread",
          32'(d[1]), 32'(d[3]));
    drain();
  endtask

  task automatic t_credit();
    int d [NCH];
    int dl;
    run_window(4'b0011, 4'b1110, 40, d, dl);
    check(d[0] == DEPTH, "R6", "words sent without pops", 32'(d[0]), 32'(DEPTH));
    check(d[1] >= 15, "R7", "other channel throughput", 32'(d[1]), 32'd15);
    check(rx_valid[0], "R6", "stalled FIFO holds words", 32'(rx_valid[0]), 32'd1);
    drain();
    run_window(4'b0001, 4'hF, 20, d, dl);
    check(d[0] == 10, "R6", "credits returned after pops", 32'(d[0]), 32'd10);
    drain();
  endtask

  task automatic t_reset_mid();
    int d [NCH];
    int dl;
    run_window(4'b0001, 4'b0000, 20, d, dl);
    check(d[0] == DEPTH, "R6", "fill before reset", 32'(d[0]), 32'(DEPTH));
    do_reset();
    cyc(1);
    check(rx_valid == '0, "R8", "FIFO emptied by reset", 32'(rx_valid), 32'd0);
    run_window(4'b0001, 4'b0000, 20, d, dl);
    check(d[0] == DEPTH, "R8", "credits full after reset", 32'(d[0]), 32'(DEPTH));
    drain();
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_full();
    t_idle();
    t_credit();
    t_reset_mid();
    for (int c = 0; c < NCH; c++)
      check(hs_rx[c] == hs_tx[c], "R3", "all accepted words delivered", 32'(hs_rx[c]), 32'(hs_tx[c]));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule